// File: doc/BRIEF.md
# Processor Reset Supervisor with Edge-Kicked Watchdog

This block produces the active-low reset line for a host processor. It watches a power-good flag that an external comparator drives. While the flag is low the reset line is held low. When the flag rises, the reset line stays low for a fixed hold time, 200 ms by default, before it is released.

The block also runs a watchdog. The host restarts the watchdog by pulling the shared chip-select/kick line from high to low. Only that falling transition restarts it. A line that stays high or stays low for longer than the selected timeout therefore counts as a hung host. When the watchdog expires, the block drives reset low for the same hold time and then starts the watchdog count again.

All times are counted from the system clock. A prescaler derives a 1 ms tick from the clock-frequency parameter.

Top module: `wdSupervisor`

## Requirements
- R1: `resetN` is active low. It is low while the block reset `rstN` is low, and it stays low after `rstN` is released for as long as `pwrGood` is low.
- R2: When `pwrGood` is sampled low, `resetN` is low from the next clock edge onward. It stays low for as long as `pwrGood` stays low.
- R3: After `pwrGood` is continuously high for HOLD_MS ticks of 1 ms, `resetN` goes high. If `pwrGood` dips low at any point during the hold, the hold count starts again from zero.
- R4: A high-to-low transition of `csKickN` restarts the watchdog count. The line passes through a two-flop synchroniser before the edge is detected. While falling edges arrive closer together than the timeout, `resetN` stays high.
- R5: When the watchdog is active and no falling edge arrives within the timeout, `resetN` goes low. This happens whether the line is held high or held low.
- R6: The `toSel` input selects the timeout:
  - 2'b00 gives 1400 ms.
  - 2'b01 gives 600 ms.
  - 2'b10 gives 200 ms.
  - 2'b11 turns the watchdog off.
  
  After an off period, the count starts from zero.
- R7: When `wdEnable` is low, the watchdog has no effect and `resetN` stays high while `pwrGood` is high.
- R8: A watchdog expiry holds `resetN` low for HOLD_MS, then releases it and restarts the watchdog count from zero.
- R9: A low-to-high transition of `csKickN` does not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_HZ |
| rstN | input | 1 | Asynchronous block reset, active low |
| pwrGood | input | 1 | Supply-good flag from an external comparator |
| csKickN | input | 1 | Shared chip-select/watchdog kick line; a falling edge restarts the watchdog |
| wdEnable | input | 1 | Watchdog enable |
| toSel | input | 2 | Timeout select (00: 1400 ms, 01: 600 ms, 10: 200 ms, 11: off) |
| resetN | output | 1 | Reset to the host processor, active low |

## Verification
The hardest situation to reach is the second watchdog period that follows an expiry. Reaching it needs a full hold, a full timeout, a forced reset and a second hold, all with `pwrGood` kept steady. The bench scales the clock parameter so that 1 ms is ten cycles. It leaves the kick line parked after an expiry and measures both the length of the forced reset and the time to the next expiry. It also reaches two other cases that are easy to miss:
- A rising edge with no falling edge, which must not restart the watchdog.
- A switch from the off code back to a live timeout.

// File: rtl/wdSupPkg.sv
package wdSupPkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic preClr;   // restart the 1 ms prescaler
    logic holdClr;  // zero the hold counter
    logic holdRun;  // let the hold counter advance on ticks
    logic wdClr;    // zero the watchdog counter
    logic wdRun;    // let the watchdog counter advance on ticks
  } supStrobe_t;

endpackage

// File: rtl/wdSupDatapath.sv
module wdSupDatapath
  import wdSupPkg::*;
#(
  parameter int DIV        = 100000,
  parameter int HOLD_TICKS = 200,
  parameter int TO_LONG    = 1400,
  parameter int TO_MID     = 600,
  parameter int TO_SHORT   = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csKickN,
  input  logic [1:0] toSel,
  input  supStrobe_t strb,
  output logic       holdDone,
  output logic       wdExpire,
  output logic       kickFall
);

  localparam int TO_MAX = (TO_LONG > TO_MID) ?
                          ((TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT) :
                          ((TO_MID > TO_SHORT) ? TO_MID : TO_SHORT);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int WW = $clog2(TO_MAX + 1);

  logic [PW-1:0] preCnt;
  logic [HW-1:0] holdCnt;
  logic [WW-1:0] wdCnt;
  logic [WW-1:0] wdLimit;
  logic [1:0]    kickSync;
  logic          kickPrev;
  logic          tick;

  // 1 ms prescaler
  assign tick = (preCnt == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      preCnt <= '0;
    else if (strb.preClr || tick)   preCnt <= '0;
    else                            preCnt <= preCnt + 1'b1;
  end

  // Power-good hold counter
  assign holdDone = (holdCnt == HW'(HOLD_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   holdCnt <= '0;
    else if (strb.holdClr)                       holdCnt <= '0;
    else if (strb.holdRun && tick && !holdDone)  holdCnt <= holdCnt + 1'b1;
  end

  // Watchdog counter and timeout mux
  always_comb begin
    case (toSel)
      2'b00:   wdLimit = WW'(TO_LONG);
      2'b01:   wdLimit = WW'(TO_MID);
      default: wdLimit = WW'(TO_SHORT);
    endcase
  end

  assign wdExpire = (wdCnt >= wdLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                wdCnt <= '0;
    else if (strb.wdClr)                      wdCnt <= '0;
    else if (strb.wdRun && tick && !wdExpire) wdCnt <= wdCnt + 1'b1;
  end

  // Kick synchroniser and falling-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kickSync <= 2'b11;
      kickPrev <= 1'b1;
    end else begin
      kickSync <= {kickSync[0], csKickN};
      kickPrev <= kickSync[1];
    end
  end

  assign kickFall = kickPrev && !kickSync[1];

endmodule

// File: rtl/wdSupControl.sv
module wdSupControl
  import wdSupPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       wdActive,
  input  logic       holdDone,
  input  logic       wdExpire,
  input  logic       kickFall,
  output supStrobe_t strb,
  output logic       resetN
);

  supState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_HOLD: begin
        strb.holdClr = !pwrGood;
        strb.holdRun = pwrGood;
        strb.wdClr   = 1'b1;
        if (pwrGood && holdDone) stateNxt = ST_RUN;
      end
      default: begin
        strb.holdClr = 1'b1;
        strb.wdClr   = kickFall || !wdActive;
        strb.wdRun   = wdActive;
        if (!pwrGood)                  stateNxt = ST_HOLD;
        else if (wdActive && wdExpire) stateNxt = ST_HOLD;
      end
    endcase
    strb.preClr = (stateNxt != state) || strb.holdClr && (state == ST_HOLD) ||
                  (state == ST_RUN && strb.wdClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  assign resetN = (state == ST_RUN);

endmodule

// File: rtl/wdSupervisor.sv
module wdSupervisor
  import wdSupPkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int HOLD_MS     = 200,
  parameter int TO_LONG_MS  = 1400,
  parameter int TO_MID_MS   = 600,
  parameter int TO_SHORT_MS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       csKickN,
  input  logic       wdEnable,
  input  logic [1:0] toSel,
  output logic       resetN
);

  localparam int DIV = CLK_HZ / 1000;

  supStrobe_t strb;
  logic holdDone, wdExpire, kickFall, wdActive;

  assign wdActive = wdEnable && (toSel != 2'b11);

  wdSupControl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pwrGood  (pwrGood),
    .wdActive (wdActive),
    .holdDone (holdDone),
    .wdExpire (wdExpire),
    .kickFall (kickFall),
    .strb     (strb),
    .resetN   (resetN)
  );

  wdSupDatapath #(
    .DIV        (DIV),
    .HOLD_TICKS (HOLD_MS),
    .TO_LONG    (TO_LONG_MS),
    .TO_MID     (TO_MID_MS),
    .TO_SHORT   (TO_SHORT_MS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .csKickN  (csKickN),
    .toSel    (toSel),
    .strb     (strb),
    .holdDone (holdDone),
    .wdExpire (wdExpire),
    .kickFall (kickFall)
  );

endmodule

// File: rtl/wdSupervisorChecker.sv
module wdSupervisorChecker #(
  parameter int HOLD_CYC = 2000
) (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic       wdEnable,
  input logic [1:0] toSel,
  input logic       resetN
);

  // Cycles that resetN has been low with pwrGood high
  int unsigned lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lowRun <= 0;
    else if (resetN || !pwrGood)  lowRun <= 0;
    else if (lowRun < HOLD_CYC)   lowRun <= lowRun + 1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_low_in_reset: assert (!resetN);
    end
  end

  a_r2_pg_low_forces_reset: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> !resetN);

  a_r3_release_needs_pg: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(pwrGood));

  a_r3_release_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (lowRun >= HOLD_CYC - 1));

  a_r7_wd_off_keeps_run: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && pwrGood && !(wdEnable && toSel != 2'b11)) |=> resetN);

endmodule

bind wdSupervisor wdSupervisorChecker #(
  .HOLD_CYC (HOLD_MS * (CLK_HZ / 1000))
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .pwrGood  (pwrGood),
  .wdEnable (wdEnable),
  .toSel    (toSel),
  .resetN   (resetN)
);

// File: tb/wdSupervisor_tb_top.sv
`timescale 1ns/1ps
module wdSupervisor_tb_top;

  localparam int CLK_HZ = 10000;          // 10 cycles per ms
  localparam int MS     = CLK_HZ / 1000;
  localparam int HOLD   = 200 * MS;
  localparam int TOL    = 3 * MS;

  // {toSel, kick level, expected cycles from release to reset}
  localparam logic [31:0] VEC [4] = '{
    {2'd0, 1'b1, 29'd14000},
    {2'd1, 1'b0, 29'd6000},
    {2'd2, 1'b1, 29'd2000},
    {2'd2, 1'b0, 29'd2000}
  };

  logic clk = 1'b0;
  logic rstN, pwrGood, csKickN, wdEnable, resetN;
  logic [1:0] toSel;
  int checks = 0;
  int failures = 0;
  int n;

  always #2 clk = ~clk;

  wdSupervisor #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .csKickN(csKickN),
    .wdEnable(wdEnable), .toSel(toSel), .resetN(resetN)
  );

  function automatic int absd(int a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitFor(input logic val, input int limit, output int cnt);
    cnt = 0;
    while (resetN !== val && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  // Cycle power-good and check the hold before release
  task automatic relPower();
    int c;
    pwrGood = 1'b0;
    repeat (5) @(negedge clk);
    pwrGood = 1'b1;
    waitFor(1'b1, HOLD + 500, c);
    check(absd(c - HOLD) <= TOL, "R3 hold", c, HOLD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; pwrGood = 1'b0; csKickN = 1'b1; wdEnable = 1'b1; toSel = 2'b00;
    repeat (5) @(negedge clk);
    check(resetN === 1'b0, "R1 in reset", resetN, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(resetN === 1'b0, "R1 pg low", resetN, 0);
    pwrGood = 1'b1;
    waitFor(1'b1, HOLD + 500, n);
    check(absd(n - HOLD) <= TOL, "R3 first release", n, HOLD);

    // R5/R6: stuck line under each timeout code
    for (int i = 0; i < 4; i++) begin
      toSel   = VEC[i][31:30];
      csKickN = VEC[i][29];
      relPower();
      waitFor(1'b0, int'(VEC[i][28:0]) + 500, n);
      check(absd(n - int'(VEC[i][28:0])) <= TOL, "R5 R6 timeout", n, int'(VEC[i][28:0]));
    end

    // R8: forced reset length, then a restarted watchdog
    waitFor(1'b1, HOLD + 500, n);
    check(absd(n - HOLD) <= TOL, "R8 expiry hold", n, HOLD);
    waitFor(1'b0, 2500, n);
    check(absd(n - 2000) <= TOL, "R8 restart", n, 2000);

    // R4: periodic kicks keep reset high
    toSel = 2'b10; csKickN = 1'b1;
    relPower();
    for (int k = 0; k < 6; k++) begin
      repeat (1450) @(negedge clk);
      csKickN = 1'b0;
      repeat (50) @(negedge clk);
      csKickN = 1'b1;
      check(resetN === 1'b1, "R4 kicked", resetN, 1);
    end
    waitFor(1'b0, 2500, n);
    check(absd(n - 1950) <= TOL, "R4 after last kick", n, 1950);

    // R9: a rising edge alone does not restart
    csKickN = 1'b0;
    relPower();
    repeat (1000) @(negedge clk);
    csKickN = 1'b1;
    waitFor(1'b0, 2500, n);
    check(absd(n - 1000) <= TOL, "R9 rising ignored", n, 1000);

    // R7: enable low
    wdEnable = 1'b0;
    relPower();
    repeat (5000) @(negedge clk);
    check(resetN === 1'b1, "R7 disabled", resetN, 1);

    // R6: off code, then back to a live timeout
    wdEnable = 1'b1; toSel = 2'b11;
    repeat (16000) @(negedge clk);
    check(resetN === 1'b1, "R6 off code", resetN, 1);
    toSel = 2'b10;
    waitFor(1'b0, 2500, n);
    check(absd(n - 2000) <= TOL, "R6 resume", n, 2000);

    // R2: power loss, and a dip during the hold
    toSel = 2'b11;
    relPower();
    pwrGood = 1'b0;
    @(negedge clk);
    check(resetN === 1'b0, "R2 next edge", resetN, 0);
    repeat (3000) @(negedge clk);
    check(resetN === 1'b0, "R2 stays low", resetN, 0);
    pwrGood = 1'b1;
    repeat (1000) @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    pwrGood = 1'b1;
    waitFor(1'b1, HOLD + 500, n);
    check(absd(n - HOLD) <= TOL, "R3 dip restarts hold", n, HOLD);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule